// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block sits behind a display link receiver that has already decoded each pixel into red, green and blue lanes. It receives one pixel word per valid input cycle, along with a data-enable flag, horizontal and vertical sync flags and three control flags. It places the pixels on two registered 24-bit buses, an even bus and an odd bus. In single mode each pixel appears on the even bus in turn and the odd bus stays at zero. In paired mode two consecutive pixels leave together, the first on the even bus and the second on the odd bus.

During blanking only the sync and control outputs change. During active video only the pixel buses change. In paired mode the odd bus can be delayed by one cycle after the even bus, which spreads switching current over time. When a line ends on an unpaired pixel, that pixel is sent with a zero-filled odd slot, and a fill flag marks it. A clock-enable output either stays high all the time or follows the registered data-enable, so that a panel which clocks only on active data can be driven from it. A registered edge-polarity output tells the pad logic which output clock edge launches the data.

Top module: `dual_pix_fmt`

## Requirements
- R1: While reset is asserted and right after it is released, every output is zero: both buses, the output data-enable, the syncs, the control flags, the strobe, the fill flag, the clock enable and the edge-polarity output.
- R2: On a valid cycle with data-enable low, the output syncs and control flags take the input values at the next clock edge. Apart from the flush in R7, the even bus keeps its value.
- R3: On a valid cycle with data-enable high, the output syncs and control flags keep their values, and the output data-enable becomes 1 at the next edge.
- R4: With the pair-mode input low, every valid active pixel appears on the even bus at the next clock edge, in arrival order, and the odd bus reads zero.
- R5: With the pair-mode input high, the first pixel of each pair is held back. When the second pixel arrives, the next edge puts the first pixel on the even bus and the second on the odd bus, and the strobe output is 1 for that one cycle. A lone first pixel raises no strobe.
- R6: The pixel that starts each active line is always treated as the even (first) member of a pair.
- R7: In pair mode, if a line ends on an unpaired pixel, the first valid blanking cycle sends that pixel on the even bus with zero on the odd bus and sets the fill flag. A complete pair clears the fill flag.
- R8: In pair mode with the active-low stagger input at 0, the odd bus updates one clock edge after the even bus. In single mode the stagger input has no effect.
- R9: With the gate-select input high, the clock enable is 0 whenever the registered data-enable is 0 and 1 when it is 1. With the gate-select input low, the clock enable is 1.
- R10: The edge-polarity output follows the polarity input one edge later, where 1 means the rising edge.
- R11: The lanes are placed as blue in bits 7:0, green in bits 15:8 and red in bits 23:16 on both buses.
- R12: A cycle with the valid input low changes no output except the clock enable and the edge-polarity output, and it does not advance the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_de | input | 1 | Input data-enable, 1 = active video |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_ctl | input | 3 | Input control flags |
| in_red | input | 8 | Red lane of the input pixel |
| in_grn | input | 8 | Green lane of the input pixel |
| in_blu | input | 8 | Blue lane of the input pixel |
| cfg_two_pix | input | 1 | 1 = paired output, 0 = single output |
| cfg_stag_n | input | 1 | 0 = delay the odd bus by one cycle in paired mode |
| cfg_gate_clk | input | 1 | 1 = clock enable follows data-enable |
| cfg_rise_edge | input | 1 | 1 = launch on the rising edge |
| even_bus | output | 24 | Even pixel bus |
| odd_bus | output | 24 | Odd pixel bus |
| out_de | output | 1 | Registered data-enable |
| out_hs | output | 1 | Registered horizontal sync |
| out_vs | output | 1 | Registered vertical sync |
| out_ctl | output | 3 | Registered control flags |
| pix_stb | output | 1 | One-cycle strobe when a new even-bus word is sent |
| odd_fill | output | 1 | Last sent odd slot was zero-filled |
| clk_en | output | 1 | Output clock enable |
| launch_rise | output | 1 | Registered launch-edge select |

## Verification
Every result is due one clock edge after the input cycle that causes it. There is one exception: the odd bus in staggered paired mode is due two edges after the second pixel of the pair. The bench applies stimulus at the falling edge and reads the outputs at the next falling edge, which lies after exactly one rising edge. For the staggered case it checks once at that point, to confirm the odd bus still shows the previous pair, and again one cycle later to confirm the new odd pixel has arrived.

// File: rtl/pxf_pkg.sv
package pxf_pkg;

  typedef enum logic {SLOT_FIRST = 1'b0, SLOT_SECOND = 1'b1} slot_e;

  typedef struct packed {
    logic emit;   // send a word this cycle
    logic stash;  // keep pixel as first of a pair
    logic flush;  // send lone first pixel with empty second slot
  } pair_act_t;

  // Decide what the pairing logic does with the current input cycle.
  function automatic pair_act_t pair_decide(input logic two, input logic valid,
                                            input logic de, input logic have_first);
    pair_act_t r;
    r = '0;
    if (valid) begin
      if (!two) begin
        r.emit = de;
      end else if (de) begin
        if (have_first) r.emit = 1'b1;
        else            r.stash = 1'b1;
      end else if (have_first) begin
        r.emit  = 1'b1;
        r.flush = 1'b1;
      end
    end
    return r;
  endfunction

  // Clock enable after the coming edge, given gating mode and next data-enable.
  function automatic logic clk_en_next(input logic gate, input logic de_next);
    return !gate || de_next;
  endfunction

endpackage

// File: rtl/pxf_pair.sv
module pxf_pair #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_pix,
  input  logic             valid,
  input  logic             de,
  input  logic [PIX_W-1:0] pix,
  output logic             emit,
  output logic             flush,
  output logic [PIX_W-1:0] ev_pix,
  output logic [PIX_W-1:0] od_pix
);
  import pxf_pkg::*;

  slot_e            slot_q;
  logic [PIX_W-1:0] stash_q;
  pair_act_t        act;

  always_comb act = pair_decide(two_pix, valid, de, slot_q == SLOT_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_FIRST;
      stash_q <= '0;
    end else if (!two_pix) begin
      slot_q <= SLOT_FIRST;
    end else if (act.stash) begin
      stash_q <= pix;
      slot_q  <= SLOT_SECOND;
    end else if (act.emit) begin
      slot_q <= SLOT_FIRST;
    end
  end

  assign emit   = act.emit;
  assign flush  = act.flush;
  assign ev_pix = two_pix ? stash_q : pix;
  assign od_pix = (!two_pix || act.flush) ? '0 : pix;

endmodule

// File: rtl/pxf_outreg.sv
module pxf_outreg #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_pix,
  input  logic             stag_n,
  input  logic             emit,
  input  logic             flush,
  input  logic [PIX_W-1:0] ev_pix,
  input  logic [PIX_W-1:0] od_pix,
  output logic [PIX_W-1:0] even_bus,
  output logic [PIX_W-1:0] odd_bus,
  output logic             pix_stb,
  output logic             odd_fill
);
  logic             stagger;
  logic             odd_pend_q;
  logic [PIX_W-1:0] odd_hold_q;

  assign stagger = two_pix && !stag_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_bus <= '0;
      pix_stb  <= 1'b0;
      odd_fill <= 1'b0;
    end else begin
      pix_stb <= emit;
      if (emit) begin
        even_bus <= ev_pix;
        odd_fill <= flush;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_bus    <= '0;
      odd_hold_q <= '0;
      odd_pend_q <= 1'b0;
    end else if (!two_pix) begin
      odd_bus    <= '0;
      odd_pend_q <= 1'b0;
    end else begin
      if (odd_pend_q) begin
        odd_bus    <= odd_hold_q;
        odd_pend_q <= 1'b0;
      end
      if (emit) begin
        if (stagger) begin
          odd_hold_q <= od_pix;
          odd_pend_q <= 1'b1;
        end else begin
          odd_bus <= od_pix;
        end
      end
    end
  end

endmodule

// File: rtl/pxf_sync.sv
module pxf_sync #(
  parameter int unsigned CTL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             de,
  input  logic             hs,
  input  logic             vs,
  input  logic [CTL_W-1:0] ctl,
  input  logic             gate_clk,
  input  logic             rise_edge,
  output logic             out_de,
  output logic             out_hs,
  output logic             out_vs,
  output logic [CTL_W-1:0] out_ctl,
  output logic             clk_en,
  output logic             launch_rise
);
  import pxf_pkg::*;

  logic de_next;
  assign de_next = valid ? de : out_de;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_de      <= 1'b0;
      out_hs      <= 1'b0;
      out_vs      <= 1'b0;
      out_ctl     <= '0;
      clk_en      <= 1'b0;
      launch_rise <= 1'b0;
    end else begin
      out_de      <= de_next;
      clk_en      <= clk_en_next(gate_clk, de_next);
      launch_rise <= rise_edge;
      if (valid && !de) begin
        out_hs  <= hs;
        out_vs  <= vs;
        out_ctl <= ctl;
      end
    end
  end

endmodule

// File: rtl/dual_pix_fmt.sv
module dual_pix_fmt #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned CTL_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_de,
  input  logic                in_hs,
  input  logic                in_vs,
  input  logic [CTL_W-1:0]    in_ctl,
  input  logic [LANE_W-1:0]   in_red,
  input  logic [LANE_W-1:0]   in_grn,
  input  logic [LANE_W-1:0]   in_blu,
  input  logic                cfg_two_pix,
  input  logic                cfg_stag_n,
  input  logic                cfg_gate_clk,
  input  logic                cfg_rise_edge,
  output logic [3*LANE_W-1:0] even_bus,
  output logic [3*LANE_W-1:0] odd_bus,
  output logic                out_de,
  output logic                out_hs,
  output logic                out_vs,
  output logic [CTL_W-1:0]    out_ctl,
  output logic                pix_stb,
  output logic                odd_fill,
  output logic                clk_en,
  output logic                launch_rise
);
  localparam int unsigned PIX_W = 3 * LANE_W;

  // R11: lane order red | green | blue, blue in the low byte
  logic [PIX_W-1:0] in_pix;
  assign in_pix = {in_red, in_grn, in_blu};

  // internal events, named for the checker
  logic             pair_emit;
  logic             pair_flush;
  logic [PIX_W-1:0] pair_ev;
  logic [PIX_W-1:0] pair_od;

  pxf_pair #(.PIX_W(PIX_W)) pair_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .two_pix (cfg_two_pix),
    .valid   (in_valid),
    .de      (in_de),
    .pix     (in_pix),
    .emit    (pair_emit),
    .flush   (pair_flush),
    .ev_pix  (pair_ev),
    .od_pix  (pair_od)
  );

  pxf_outreg #(.PIX_W(PIX_W)) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .two_pix  (cfg_two_pix),
    .stag_n   (cfg_stag_n),
    .emit     (pair_emit),
    .flush    (pair_flush),
    .ev_pix   (pair_ev),
    .od_pix   (pair_od),
    .even_bus (even_bus),
    .odd_bus  (odd_bus),
    .pix_stb  (pix_stb),
    .odd_fill (odd_fill)
  );

  pxf_sync #(.CTL_W(CTL_W)) sync_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (in_valid),
    .de          (in_de),
    .hs          (in_hs),
    .vs          (in_vs),
    .ctl         (in_ctl),
    .gate_clk    (cfg_gate_clk),
    .rise_edge   (cfg_rise_edge),
    .out_de      (out_de),
    .out_hs      (out_hs),
    .out_vs      (out_vs),
    .out_ctl     (out_ctl),
    .clk_en      (clk_en),
    .launch_rise (launch_rise)
  );

endmodule

// File: rtl/dual_pix_fmt_chk.sv
module dual_pix_fmt_chk #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_de,
  input logic             cfg_two_pix,
  input logic             cfg_stag_n,
  input logic             cfg_gate_clk,
  input logic             cfg_rise_edge,
  input logic [PIX_W-1:0] even_bus,
  input logic [PIX_W-1:0] odd_bus,
  input logic             out_de,
  input logic             out_hs,
  input logic             clk_en,
  input logic             launch_rise,
  input logic             pix_stb,
  input logic             odd_fill,
  input logic             pair_emit,
  input logic             pair_flush
);

  // R2
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_de && !pair_flush) |=> $stable(even_bus));

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_de) |=> ($stable(out_hs) && out_de));

  // R4
  odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_two_pix |=> (odd_bus == '0));

  // R5
  pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_two_pix && pair_emit) |=> (!pair_emit || !cfg_two_pix));

  // R7
  fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_two_pix && cfg_stag_n && pair_flush) |=> (odd_fill && odd_bus == '0));

  // R8
  stag_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_two_pix && !cfg_stag_n && pair_emit) |=> (pix_stb && $stable(odd_bus)));

  // R9
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate_clk && in_valid && !in_de) |=> !clk_en);

  // R9
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_gate_clk |=> clk_en);

  // R10
  rise_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rise_edge |=> launch_rise);

  // R10
  fall_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rise_edge |=> !launch_rise);

endmodule

bind dual_pix_fmt dual_pix_fmt_chk chk_i (.*);

// File: tb/dual_pix_fmt_tb.sv
module dual_pix_fmt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [2:0]  in_ctl = '0;
  logic [7:0]  in_red = '0, in_grn = '0, in_blu = '0;
  logic        cfg_two_pix = 1'b0, cfg_stag_n = 1'b1, cfg_gate_clk = 1'b0, cfg_rise_edge = 1'b1;
  logic [23:0] even_bus, odd_bus;
  logic        out_de, out_hs, out_vs, pix_stb, odd_fill, clk_en, launch_rise;
  logic [2:0]  out_ctl;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_pix_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_de(in_de), .in_hs(in_hs),
    .in_vs(in_vs), .in_ctl(in_ctl), .in_red(in_red), .in_grn(in_grn), .in_blu(in_blu),
    .cfg_two_pix(cfg_two_pix), .cfg_stag_n(cfg_stag_n), .cfg_gate_clk(cfg_gate_clk),
    .cfg_rise_edge(cfg_rise_edge), .even_bus(even_bus), .odd_bus(odd_bus),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_ctl(out_ctl),
    .pix_stb(pix_stb), .odd_fill(odd_fill), .clk_en(clk_en), .launch_rise(launch_rise)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected word for pixel n: red=n, green=n+1, blue=n+2
  function automatic logic [23:0] word(input logic [7:0] n);
    return {n, n + 8'd1, n + 8'd2};
  endfunction

  // drive an active pixel, then step to the next falling edge
  task automatic px(input logic [7:0] n);
    in_valid = 1'b1; in_de = 1'b1;
    in_red = n; in_grn = n + 8'd1; in_blu = n + 8'd2;
    in_hs = ~out_hs; in_ctl = ~out_ctl;
    @(negedge clk);
  endtask

  task automatic blank(input logic hs, input logic vs, input logic [2:0] ctl);
    in_valid = 1'b1; in_de = 1'b0;
    in_hs = hs; in_vs = vs; in_ctl = ctl;
    in_red = 8'hEE; in_grn = 8'hDD; in_blu = 8'hCC;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0; in_de = 1'b1;
    in_red = 8'h55; in_grn = 8'h66; in_blu = 8'h77; in_hs = 1'b1; in_ctl = 3'd2;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 even", {8'h0, even_bus}, 0);
    chk("R1 odd", {8'h0, odd_bus}, 0);
    chk("R1 flags", {out_de, out_hs, out_vs, out_ctl, pix_stb, odd_fill, clk_en, launch_rise}, 0);
  endtask

  task automatic t_blank();
    blank(1'b1, 1'b0, 3'd5);
    chk("R2 syncs", {out_hs, out_vs, out_ctl}, {1'b1, 1'b0, 3'd5});
    chk("R2 even unchanged", {8'h0, even_bus}, 0);
    px(8'h10);
    chk("R3 syncs held", {out_hs, out_vs, out_ctl}, {1'b1, 1'b0, 3'd5});
    chk("R3 de", {31'h0, out_de}, 1);
  endtask

  task automatic t_single();
    blank(1'b0, 1'b0, 3'd0);
    px(8'h20);
    chk("R4 first", {8'h0, even_bus}, word(8'h20));
    chk("R11 blue lane", {24'h0, even_bus[7:0]}, 32'h22);
    chk("R11 red lane", {24'h0, even_bus[23:16]}, 32'h20);
    px(8'h30);
    chk("R4 second", {8'h0, even_bus}, word(8'h30));
    chk("R4 odd zero", {8'h0, odd_bus}, 0);
    cfg_stag_n = 1'b0;
    px(8'h40);
    chk("R8 ignored single", {8'h0, even_bus}, word(8'h40));
    chk("R8 odd zero single", {8'h0, odd_bus}, 0);
    cfg_stag_n = 1'b1;
    idle();
    chk("R12 no change", {8'h0, even_bus}, word(8'h40));
    chk("R12 syncs", {out_hs, out_ctl}, {1'b0, 3'd0});
  endtask

  task automatic t_pair();
    cfg_two_pix = 1'b1;
    blank(1'b0, 1'b0, 3'd0);
    px(8'h50);
    chk("R5 no strobe on first", {31'h0, pix_stb}, 0);
    idle();
    px(8'h60);
    chk("R12 pairing kept", {8'h0, even_bus}, word(8'h50));
    chk("R5 odd", {8'h0, odd_bus}, word(8'h60));
    chk("R5 strobe", {31'h0, pix_stb}, 1);
    px(8'h70);
    chk("R5 strobe drops", {31'h0, pix_stb}, 0);
    blank(1'b0, 1'b0, 3'd0);
    chk("R7 flush even", {8'h0, even_bus}, word(8'h70));
    chk("R7 flush odd zero", {8'h0, odd_bus}, 0);
    chk("R7 fill flag", {31'h0, odd_fill}, 1);
    px(8'h80);
    px(8'h90);
    chk("R6 line start even", {8'h0, even_bus}, word(8'h80));
    chk("R6 line start odd", {8'h0, odd_bus}, word(8'h90));
    chk("R7 fill cleared", {31'h0, odd_fill}, 0);
  endtask

  task automatic t_stagger();
    cfg_stag_n = 1'b0;
    blank(1'b0, 1'b0, 3'd0);
    px(8'hA0);
    px(8'hB0);
    chk("R8 even now", {8'h0, even_bus}, word(8'hA0));
    chk("R8 odd late", {8'h0, odd_bus}, word(8'h90));
    idle();
    chk("R8 odd arrives", {8'h0, odd_bus}, word(8'hB0));
    cfg_stag_n = 1'b1;
  endtask

  task automatic t_gate();
    cfg_gate_clk = 1'b1;
    blank(1'b0, 1'b0, 3'd0);
    chk("R9 gated low", {31'h0, clk_en}, 0);
    px(8'h11);
    chk("R9 gated high", {31'h0, clk_en}, 1);
    cfg_gate_clk = 1'b0;
    blank(1'b0, 1'b0, 3'd0);
    chk("R9 free run", {31'h0, clk_en}, 1);
  endtask

  task automatic t_pol();
    cfg_rise_edge = 1'b0;
    idle();
    chk("R10 falling", {31'h0, launch_rise}, 0);
    cfg_rise_edge = 1'b1;
    idle();
    chk("R10 rising", {31'h0, launch_rise}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {8'h0, even_bus}, 0);
    t_blank();
    t_single();
    t_pair();
    t_stagger();
    t_gate();
    t_pol();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule